// File: doc/BRIEF.md
# SCSI Adapter DMA Control Channel

This block is the register-mapped control side of a bus-master DMA channel in a SCSI host adapter. Software programs a start byte count, a start address and a start descriptor-list address, then issues a command through a two-bit opcode. A start command loads the working copies of those three values, clears the status flags and raises a DMA request level toward the SCSI core. The other opcodes are idle, blast and abort. Idle drops the request, blast sets a completion flag, and abort sends a one-cycle cancel pulse to the core.

As the bus-master datapath moves data, it presents one chunk at a time with a requested length and a direction. The block clips the chunk to the remaining working count and returns the granted length. It then lowers the working count and advances the working address by that amount. The SCSI core interrupt is folded into the status word. On a rising edge during a started transfer whose count has run out, the done flag is also set. A single registered level interrupt combines the core flag with the done flag when done interrupts are enabled.

Status flags are cleared in one of two ways, chosen by a mode input. In one mode a status read clears them. In the other mode software writes ones to the flags it wants to clear.

Top module: `scsi_dma_ctrl`

## Requirements
- R1: After reset, the command and status registers read 0, the working count reads 0, the working address reads 0xFFFFFFFF and the working descriptor address reads 0xFFFFFFFD. The DMA request, cancel pulse and interrupt outputs are low.
- R2: The register word offsets are 0 command, 1 start count, 2 start address, 3 working count, 4 working address, 5 status, 6 start descriptor address and 7 working descriptor address. A command write with opcode bits [1:0] = 3 (start) does three things at once. It copies offsets 1, 2 and 6 into offsets 3, 4 and 7, it clears status bits 5..0, and it raises the DMA request.
- R3: Opcode 0 (idle) lowers the DMA request. Opcode 1 (blast) sets status bit 5.
- R4: Opcode 2 (abort) drives the cancel output high for exactly the one cycle after the command write.
- R5: Writes to offsets 3, 4 and 7 leave those registers unchanged.
- R6: A chunk whose direction matches command bit 7 (1 = device to memory) is granted min(requested length, working count). The working count then drops by the grant and the working address rises by the grant.
- R7: A chunk whose direction differs from command bit 7 gets a grant of 0, and the working count and working address do not change.
- R8: A rising core interrupt sets status bit 4. If the opcode held in the command register is start and the working count is 0, the same edge also sets status bit 3 (done). A falling core interrupt clears status bit 4.
- R9: With the mode input low, a status read returns the current value and then clears bits 1, 2 and 3. Status writes have no effect in this mode.
- R10: With the mode input high, status reads clear nothing. A status write clears each of bits 1, 2 and 3 that is written as 1.
- R11: The interrupt output equals status bit 4 OR (command bit 6 AND status bit 3), as that expression stood one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (qualifies read side effects) |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed register, combinational |
| stat_w1c_i | input | 1 | Status clear mode: 1 write-one-to-clear, 0 clear-on-read |
| xfer_valid_i | input | 1 | A chunk is transferred this cycle |
| xfer_dir_i | input | 1 | Chunk direction, 1 = device to memory |
| xfer_len_i | input | 16 | Requested chunk length in bytes |
| xfer_grant_o | output | 16 | Granted chunk length, 0 when the direction does not match |
| xfer_addr_o | output | 32 | Current working address for the chunk |
| core_irq_i | input | 1 | Interrupt level from the SCSI core |
| dma_req_o | output | 1 | DMA request level to the SCSI core |
| cancel_o | output | 1 | One-cycle request-cancel pulse to the SCSI core |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest state to reach is the done flag. It needs a started transfer, a working count drained to exactly zero by clipped chunks, and then a fresh rising edge on the core interrupt. The bench sweeps every start count from 0 to 9 against chunk lengths 1 to 4, which drains the count through every clipping pattern. It then raises the core interrupt and runs the done flag through both clearing modes. With done interrupts enabled and disabled, it checks that the interrupt output holds or falls when the core line drops.

// File: rtl/scsi_dma_pkg.sv
package scsi_dma_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_BLAST = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } dma_op_e;

  localparam logic [2:0] OFS_CMD  = 3'd0;
  localparam logic [2:0] OFS_SCNT = 3'd1;
  localparam logic [2:0] OFS_SADR = 3'd2;
  localparam logic [2:0] OFS_WCNT = 3'd3;
  localparam logic [2:0] OFS_WADR = 3'd4;
  localparam logic [2:0] OFS_STAT = 3'd5;
  localparam logic [2:0] OFS_SDSC = 3'd6;
  localparam logic [2:0] OFS_WDSC = 3'd7;

  localparam int CMD_DONE_IE = 6;
  localparam int CMD_DIR     = 7;

  localparam int STAT_W   = 6;
  localparam int ST_ERR   = 1;
  localparam int ST_ABT   = 2;
  localparam int ST_DONE  = 3;
  localparam int ST_CORE  = 4;
  localparam int ST_BLAST = 5;
endpackage

// File: rtl/scsi_dma_walk.sv
module scsi_dma_walk #(
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] cnt_start_i,
  input  logic [DW-1:0] adr_start_i,
  input  logic [DW-1:0] dsc_start_i,
  input  logic          step_i,
  input  logic [LW-1:0] req_len_i,
  output logic [LW-1:0] grant_o,
  output logic [DW-1:0] wcnt_o,
  output logic [DW-1:0] wadr_o,
  output logic [DW-1:0] wdsc_o
);
  localparam logic [DW-1:0] ADR_RST = '1;
  localparam logic [DW-1:0] DSC_RST = ~DW'(2);

  logic [DW-1:0] wcnt_q, wadr_q, wdsc_q;

  // clip the chunk to what is left
  always_comb begin
    if (wcnt_q < DW'(req_len_i)) grant_o = wcnt_q[LW-1:0];
    else                         grant_o = req_len_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      wadr_q <= ADR_RST;
      wdsc_q <= DSC_RST;
    end else if (load_i) begin
      wcnt_q <= cnt_start_i;
      wadr_q <= adr_start_i;
      wdsc_q <= dsc_start_i;
    end else if (step_i) begin
      wcnt_q <= wcnt_q - DW'(grant_o);
      wadr_q <= wadr_q + DW'(grant_o);
    end
  end

  assign wcnt_o = wcnt_q;
  assign wadr_o = wadr_q;
  assign wdsc_o = wdsc_q;
endmodule

// File: rtl/scsi_dma_status.sv
module scsi_dma_status
  import scsi_dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              blast_i,
  input  logic              core_rise_i,
  input  logic              core_fall_i,
  input  logic              done_cond_i,
  input  logic [STAT_W-1:0] clr_i,
  input  logic              done_ie_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] stat_q, set_vec, clr_vec;
  logic              irq_q;

  always_comb begin
    set_vec           = '0;
    set_vec[ST_BLAST] = blast_i;
    set_vec[ST_CORE]  = core_rise_i;
    set_vec[ST_DONE]  = core_rise_i & done_cond_i;
    clr_vec           = clr_i;
    clr_vec[ST_CORE]  = clr_i[ST_CORE] | core_fall_i;
  end

  // start clears everything, explicit clears next, sets win
  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         stat_q[b] <= 1'b0;
      else if (set_vec[b]) stat_q[b] <= 1'b1;
      else if (start_i)    stat_q[b] <= 1'b0;
      else if (clr_vec[b]) stat_q[b] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= stat_q[ST_CORE] | (done_ie_i & stat_q[ST_DONE]);
  end

  assign stat_o = stat_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/scsi_dma_ctrl.sv
module scsi_dma_ctrl
  import scsi_dma_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          stat_w1c_i,
  input  logic          xfer_valid_i,
  input  logic          xfer_dir_i,
  input  logic [LW-1:0] xfer_len_i,
  output logic [LW-1:0] xfer_grant_o,
  output logic [DW-1:0] xfer_addr_o,
  input  logic          core_irq_i,
  output logic          dma_req_o,
  output logic          cancel_o,
  output logic          irq_o
);
  localparam logic [STAT_W-1:0] CLR_MASK = STAT_W'((1 << ST_ERR) | (1 << ST_ABT) | (1 << ST_DONE));

  logic [DW-1:0]     cmd_q, scnt_q, sadr_q, sdsc_q;
  logic [DW-1:0]     wcnt, wadr, wdsc;
  logic [STAT_W-1:0] stat, clr;
  logic              dma_req_q, cancel_q, core_q;
  logic              cmd_wr, stat_wr, stat_rd;
  logic              op_start, op_idle, op_blast, op_abort;
  logic              step, done_cond;
  logic [LW-1:0]     grant;
  dma_op_e           op_w, op_cur;

  assign op_w     = dma_op_e'(reg_wdata_i[1:0]);
  assign op_cur   = dma_op_e'(cmd_q[1:0]);
  assign cmd_wr   = reg_wr_i && (reg_addr_i == OFS_CMD);
  assign stat_wr  = reg_wr_i && (reg_addr_i == OFS_STAT);
  assign stat_rd  = reg_rd_i && (reg_addr_i == OFS_STAT);
  assign op_start = cmd_wr && (op_w == OP_START);
  assign op_idle  = cmd_wr && (op_w == OP_IDLE);
  assign op_blast = cmd_wr && (op_w == OP_BLAST);
  assign op_abort = cmd_wr && (op_w == OP_ABORT);

  assign step      = xfer_valid_i && (xfer_dir_i == cmd_q[CMD_DIR]);
  assign done_cond = (op_cur == OP_START) && (wcnt == '0);

  always_comb begin
    clr = '0;
    if (stat_w1c_i && stat_wr)  clr = reg_wdata_i[STAT_W-1:0] & CLR_MASK;
    if (!stat_w1c_i && stat_rd) clr = CLR_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= '0;
      scnt_q    <= '0;
      sadr_q    <= '0;
      sdsc_q    <= '0;
      dma_req_q <= 1'b0;
      cancel_q  <= 1'b0;
      core_q    <= 1'b0;
    end else begin
      core_q   <= core_irq_i;
      cancel_q <= op_abort;
      if (cmd_wr) cmd_q <= reg_wdata_i;
      if (reg_wr_i && reg_addr_i == OFS_SCNT) scnt_q <= reg_wdata_i;
      if (reg_wr_i && reg_addr_i == OFS_SADR) sadr_q <= reg_wdata_i;
      if (reg_wr_i && reg_addr_i == OFS_SDSC) sdsc_q <= reg_wdata_i;
      if (op_start)     dma_req_q <= 1'b1;
      else if (op_idle) dma_req_q <= 1'b0;
    end
  end

  scsi_dma_walk #(.DW(DW), .LW(LW)) u_walk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (op_start),
    .cnt_start_i(scnt_q),
    .adr_start_i(sadr_q),
    .dsc_start_i(sdsc_q),
    .step_i     (step && !op_start),
    .req_len_i  (xfer_len_i),
    .grant_o    (grant),
    .wcnt_o     (wcnt),
    .wadr_o     (wadr),
    .wdsc_o     (wdsc)
  );

  scsi_dma_status u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (op_start),
    .blast_i    (op_blast),
    .core_rise_i(core_irq_i && !core_q),
    .core_fall_i(!core_irq_i && core_q),
    .done_cond_i(done_cond),
    .clr_i      (clr),
    .done_ie_i  (cmd_q[CMD_DONE_IE]),
    .stat_o     (stat),
    .irq_o      (irq_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      OFS_CMD:  reg_rdata_o = cmd_q;
      OFS_SCNT: reg_rdata_o = scnt_q;
      OFS_SADR: reg_rdata_o = sadr_q;
      OFS_WCNT: reg_rdata_o = wcnt;
      OFS_WADR: reg_rdata_o = wadr;
      OFS_STAT: reg_rdata_o = DW'(stat);
      OFS_SDSC: reg_rdata_o = sdsc_q;
      default:  reg_rdata_o = wdsc;
    endcase
  end

  assign xfer_grant_o = step ? grant : '0;
  assign xfer_addr_o  = wadr;
  assign dma_req_o    = dma_req_q;
  assign cancel_o     = cancel_q;
endmodule

// File: rtl/scsi_dma_chk.sv
module scsi_dma_chk
  import scsi_dma_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_wr,
  input logic              op_abort,
  input logic              op_start,
  input logic              reg_wr_i,
  input logic [2:0]        reg_addr_i,
  input logic              step,
  input logic [LW-1:0]     grant,
  input logic [DW-1:0]     wcnt,
  input logic [DW-1:0]     wadr,
  input logic [DW-1:0]     cmd_q,
  input logic [STAT_W-1:0] stat,
  input logic              core_irq_i,
  input logic              cancel_o,
  input logic              irq_o
);
  assert_cancel_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_o |=> !cancel_o);

  assert_cancel_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_o |-> $past(cmd_wr && op_abort));

  assert_wreg_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && (reg_addr_i == OFS_WCNT || reg_addr_i == OFS_WADR) && !step) |=>
      ($stable(wcnt) && $stable(wadr)));

  assert_grant_clip_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |-> (DW'(grant) <= wcnt));

  assert_step_update_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !op_start) |=> (wcnt + DW'($past(grant)) == $past(wcnt)) &&
                            (wadr - DW'($past(grant)) == $past(wadr)));

  assert_core_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_irq_i) |=> stat[ST_CORE]);

  assert_irq_follow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stat[ST_CORE] | (cmd_q[CMD_DONE_IE] & stat[ST_DONE])) |-> irq_o);
endmodule

bind scsi_dma_ctrl scsi_dma_chk #(.DW(DW), .LW(LW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cmd_wr    (cmd_wr),
  .op_abort  (op_abort),
  .op_start  (op_start),
  .reg_wr_i  (reg_wr_i),
  .reg_addr_i(reg_addr_i),
  .step      (step),
  .grant     (grant),
  .wcnt      (wcnt),
  .wadr      (wadr),
  .cmd_q     (cmd_q),
  .stat      (stat),
  .core_irq_i(core_irq_i),
  .cancel_o  (cancel_o),
  .irq_o     (irq_o)
);

// File: tb/scsi_dma_ctrl_tb.sv
module scsi_dma_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        stat_w1c_i = 1'b0;
  logic        xfer_valid_i = 1'b0, xfer_dir_i = 1'b0;
  logic [15:0] xfer_len_i = '0, xfer_grant_o;
  logic [31:0] xfer_addr_o;
  logic        core_irq_i = 1'b0;
  logic        dma_req_o, cancel_o, irq_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  scsi_dma_ctrl dut_i (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    reg_wr_i = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_rd_i = 1; reg_addr_i = a;
    #1 v = reg_rdata_o;
    @(posedge clk_i); @(negedge clk_i);
    reg_rd_i = 0;
  endtask

  task automatic chunk(input logic [15:0] len, input logic dir, output logic [15:0] g);
    xfer_valid_i = 1; xfer_len_i = len; xfer_dir_i = dir;
    #1 g = xfer_grant_o;
    @(posedge clk_i); @(negedge clk_i);
    xfer_valid_i = 0;
  endtask

  task automatic rchk(input logic [2:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(a, v);
    check(v === exp, req, v, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [15:0] g;
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    stat_w1c_i = 1; // no read side effects while checking reset values

    // R1 reset state
    rchk(3'd0, 32'h0, "R1 cmd");
    rchk(3'd3, 32'h0, "R1 wcnt");
    rchk(3'd4, 32'hFFFF_FFFF, "R1 wadr");
    rchk(3'd7, 32'hFFFF_FFFD, "R1 wdsc");
    rchk(3'd5, 32'h0, "R1 stat");
    check({dma_req_o, cancel_o, irq_o} === 3'b000, "R1 outs", {dma_req_o, cancel_o, irq_o}, 0);

    // R3 blast, then R2 start clears it
    wr(3'd0, 32'h1);
    rchk(3'd5, 32'h20, "R3 blast");
    wr(3'd1, 32'd100); wr(3'd2, 32'h1000); wr(3'd6, 32'h2000);
    wr(3'd0, 32'h3);
    rchk(3'd3, 32'd100, "R2 wcnt");
    rchk(3'd4, 32'h1000, "R2 wadr");
    rchk(3'd7, 32'h2000, "R2 wdsc");
    rchk(3'd5, 32'h0, "R2 stat clr");
    check(dma_req_o === 1'b1, "R2 req", dma_req_o, 1);

    // R5 working regs ignore writes
    wr(3'd3, 32'h55); wr(3'd4, 32'h66); wr(3'd7, 32'h77);
    rchk(3'd3, 32'd100, "R5 wcnt");
    rchk(3'd4, 32'h1000, "R5 wadr");
    rchk(3'd7, 32'h2000, "R5 wdsc");

    // R7 direction mismatch (cmd dir=0, chunk dir=1)
    chunk(16'd8, 1'b1, g);
    check(g === 16'd0, "R7 grant", g, 0);
    rchk(3'd3, 32'd100, "R7 wcnt");
    rchk(3'd4, 32'h1000, "R7 wadr");

    // R3 idle
    wr(3'd0, 32'h0);
    check(dma_req_o === 1'b0, "R3 idle", dma_req_o, 0);

    // R4 abort pulse
    wr(3'd0, 32'h2);
    check(cancel_o === 1'b1, "R4 pulse on", cancel_o, 1);
    @(negedge clk_i);
    check(cancel_o === 1'b0, "R4 pulse off", cancel_o, 0);

    // R6 sweep: count x chunk length, both directions
    for (int dir = 0; dir < 2; dir++)
      for (int cnt = 0; cnt < 10; cnt++)
        for (int len = 1; len < 5; len++) begin
          int rem, pos;
          rem = cnt; pos = 0;
          wr(3'd1, cnt); wr(3'd2, 32'h4000 + cnt * 16);
          wr(3'd0, 32'h3 | (dir << 7));
          for (int k = 0; k < 4; k++) begin
            int e;
            e = (len < rem) ? len : rem;
            chunk(16'(len), 1'(dir), g);
            check(g === 16'(e), "R6 grant", g, e);
            rem -= e; pos += e;
            rchk(3'd3, rem, "R6 wcnt");
            check(xfer_addr_o === 32'h4000 + cnt * 16 + pos, "R6 wadr", xfer_addr_o, 32'h4000 + cnt * 16 + pos);
          end
        end

    // R8 rising core irq, count 0, start held -> bits 4 and 3; R11 timing
    wr(3'd1, 32'd0); wr(3'd0, 32'h43); // start, done irq enabled
    core_irq_i = 1;
    @(negedge clk_i);
    check(irq_o === 1'b0, "R11 delay", irq_o, 0);
    rchk(3'd5, 32'h18, "R8 core+done");
    check(irq_o === 1'b1, "R11 asserted", irq_o, 1);
    core_irq_i = 0;
    @(negedge clk_i);
    rchk(3'd5, 32'h08, "R8 fall");
    check(irq_o === 1'b1, "R11 done holds", irq_o, 1);

    // R10 write-one-to-clear mode
    wr(3'd5, 32'h02);
    rchk(3'd5, 32'h08, "R10 other bit kept");
    wr(3'd5, 32'h08);
    rchk(3'd5, 32'h00, "R10 cleared");
    @(negedge clk_i);
    check(irq_o === 1'b0, "R11 clears", irq_o, 0);

    // R8 with count nonzero: only bit 4
    wr(3'd1, 32'd5); wr(3'd0, 32'h3);
    core_irq_i = 1; @(negedge clk_i);
    rchk(3'd5, 32'h10, "R8 no done");
    core_irq_i = 0; @(negedge clk_i);
    @(negedge clk_i);
    check(irq_o === 1'b0, "R11 disabled", irq_o, 0);

    // R9 clear-on-read mode, done irq disabled
    wr(3'd1, 32'd0); wr(3'd0, 32'h3);
    core_irq_i = 1; @(negedge clk_i);
    stat_w1c_i = 0;
    wr(3'd5, 32'h0E);
    rchk(3'd5, 32'h18, "R9 write ignored / read value");
    rchk(3'd5, 32'h10, "R9 cleared after read");
    core_irq_i = 0; @(negedge clk_i);
    @(negedge clk_i);
    check(irq_o === 1'b0, "R11 no done ie", irq_o, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule